// File: doc/BRIEF.md
# Burst Cache Data RAM with Hidden Refresh

This block is the data store of a processor cache. It looks like a synchronous pipelined burst SRAM, but its contents sit in dynamic storage that has to be refreshed. A burst starts when either of two address strobes is seen: one belongs to the processor and one to the cache controller. Each following advance pulse steps to the next word of an aligned group of four. Reads return through a three-register pipeline. Writes are committed on the edge that accepts the beat, and each of the four byte lanes can be masked on its own.

A free-running counter schedules a short refresh interval. The refresh sequencer gets the array only between bursts. While the interval runs it raises `busy`, and every strobe or advance presented during that time is dropped. The cache controller watches `busy` and holds its next strobe until it falls. The array depth is set by a parameter. The default is kept small, and an address width of 15 gives the full 32K-word part.

Top module: `burst_cache_ram`

## Requirements
- R1: A strobe starts an access only when `chipEnN` is 0, `selHi` is 1 and `selLoN` is 0. If any of the three is off, the strobe writes nothing and produces no read data.
- R2: A read sampled at rising edge n shows its word on `rdData`, with `rdValid` high, in the cycle after edge n+2.
- R3: Each accepted advance moves address bits [1:0] to +1 modulo 4 and keeps the upper bits. A burst closes after its fourth beat, or at any edge that accepts no advance. An advance on a closed burst is ignored.
- R4: A strobe presented on the edge right after a fourth beat starts a new burst at once, so read data keeps coming one word per clock.
- R5: With `allWrN` = 0, a beat writes all four bytes, whatever `laneWrEnN` and `laneSelN` hold.
- R6: With `allWrN` = 1 and `laneWrEnN` = 0, only the bytes whose `laneSelN[i]` is 0 are written, where bit i maps to data bits [8i+7:8i]. With `allWrN` = 1 and `laneWrEnN` = 1, the beat is a read and `laneSelN` is ignored.
- R7: Either `cpuStrbN` or `ctlStrbN` low starts a burst at `addr`.
- R8: `rdValid` is high only while a read result is present and `outEnN` is 0. Otherwise `rdData` is zero. Both are low after reset.
- R9: A refresh is requested once every REF_PERIOD (256) clocks, counted from reset. `busy` stays high REF_LEN (1) cycles per refresh, so in steady idle operation it is high 4 cycles out of every 1024. `busy` is low after reset.
- R10: A pending refresh is granted only at an edge where no burst is open and no selected strobe is present. The strobe wins over the refresh.
- R11: A strobe or advance sampled while `busy` is high performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Start address of a burst |
| cpuStrbN | input | 1 | Processor address strobe, active low |
| ctlStrbN | input | 1 | Cache-controller address strobe, active low |
| burstNextN | input | 1 | Advance to the next beat, active low |
| chipEnN | input | 1 | Chip enable, active low |
| selHi | input | 1 | Select, active high |
| selLoN | input | 1 | Select, active low |
| allWrN | input | 1 | Write all bytes, active low |
| laneWrEnN | input | 1 | Enables per-byte writes, active low |
| laneSelN | input | 4 | Per-byte write selects, active low |
| outEnN | input | 1 | Output enable, active low |
| wrData | input | 32 | Write data for the beat being accepted |
| rdData | output | 32 | Read data, zero when not valid |
| rdValid | output | 1 | Read data present and enabled |
| busy | output | 1 | Refresh in progress; accesses are dropped |

## Verification
The assertions assume the controller obeys `busy`: a strobe is issued only when `busy` was low at the previous falling edge. Under that rule a refresh can never be granted inside a burst. The bench's burst tasks wait on `busy` before every strobe. The only exception is the one directed case that deliberately strobes into a refresh, which tests that the strobe is dropped. The bench also never issues a byte write with every lane deselected, because the block treats that beat as a read.

// File: rtl/cram_pkg.sv
package cram_pkg;
  localparam int BYTE_LANES = 4;
  localparam int LANE_W     = 8;
  localparam int WORD_W     = BYTE_LANES * LANE_W;

  typedef struct packed {
    logic                  rdEn;
    logic                  wrEn;
    logic [BYTE_LANES-1:0] byteEn;
  } cram_acc_t;
endpackage

// File: rtl/cram_refresh.sv
module cram_refresh #(
  parameter int REF_PERIOD = 256,
  parameter int REF_LEN    = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic inBurst,
  output logic busy
);
  localparam int CNT_W = $clog2(REF_PERIOD);
  localparam int LEN_W = $clog2(REF_LEN + 1);

  logic [CNT_W-1:0] refCnt;
  logic [LEN_W-1:0] refLeft;
  logic             refPending;
  logic             grant;
  logic             wrapNow;

  always_comb begin
    wrapNow = (refCnt == CNT_W'(REF_PERIOD - 1));
    grant   = refPending && !busy && !inBurst && !startReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
      busy       <= 1'b0;
      refLeft    <= '0;
    end else begin
      refCnt <= wrapNow ? '0 : refCnt + 1'b1;
      if (grant) refPending <= 1'b0;
      if (wrapNow) refPending <= 1'b1;
      if (grant) begin
        busy    <= 1'b1;
        refLeft <= LEN_W'(REF_LEN - 1);
      end else if (busy) begin
        if (refLeft == '0) busy <= 1'b0;
        else refLeft <= refLeft - 1'b1;
      end
    end
  end

  // checker counter: consecutive busy cycles
  logic [LEN_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  a_r9_busy_run: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < (LEN_W+1)'(REF_LEN)));

  a_r10_grant_between_bursts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!$past(inBurst) && !$past(startReq)));
endmodule

// File: rtl/cram_ctrl.sv
module cram_ctrl
  import cram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  cpuStrbN,
  input  logic                  ctlStrbN,
  input  logic                  burstNextN,
  input  logic                  chipEnN,
  input  logic                  selHi,
  input  logic                  selLoN,
  input  logic                  allWrN,
  input  logic                  laneWrEnN,
  input  logic [BYTE_LANES-1:0] laneSelN,
  input  logic                  busy,
  output cram_acc_t             acc,
  output logic [ADDR_W-1:0]     accAddr,
  output logic                  startReq,
  output logic                  inBurst
);
  localparam int LOW_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] curAddr;
  logic [LOW_W-1:0]  beatCnt;
  logic [LOW_W-1:0]  nextLow;
  logic              selected;
  logic              advReq;
  logic              issue;
  logic              isWrite;

  always_comb begin
    selected = !chipEnN && selHi && !selLoN;
    startReq = selected && (!cpuStrbN || !ctlStrbN);
    advReq   = !burstNextN && inBurst && !startReq;
    issue    = (startReq || advReq) && !busy;
    nextLow  = curAddr[LOW_W-1:0] + 1'b1;
    accAddr  = startReq ? addr : {curAddr[ADDR_W-1:LOW_W], nextLow};
    isWrite  = !allWrN || (!laneWrEnN && (laneSelN != '1));
    acc.rdEn = issue && !isWrite;
    acc.wrEn = issue && isWrite;
    if (!allWrN)         acc.byteEn = '1;
    else if (!laneWrEnN) acc.byteEn = ~laneSelN;
    else                 acc.byteEn = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      beatCnt <= '0;
      inBurst <= 1'b0;
    end else if (issue && startReq) begin
      curAddr <= accAddr;
      beatCnt <= '0;
      inBurst <= 1'b1;
    end else if (issue) begin
      curAddr <= accAddr;
      beatCnt <= beatCnt + 1'b1;
      if (beatCnt == LOW_W'(BURST_LEN - 2)) inBurst <= 1'b0;
    end else begin
      inBurst <= 1'b0;
    end
  end

  a_r11_no_burst_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !inBurst);
endmodule

// File: rtl/cram_datapath.sv
module cram_datapath
  import cram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  cram_acc_t         acc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEnN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              s1Vld, s2Vld, s3Vld;
  logic [ADDR_W-1:0] s1Addr;
  logic [WORD_W-1:0] s2Data, s3Data;

  always_ff @(posedge clk) begin
    if (acc.wrEn) begin
      for (int lane = 0; lane < BYTE_LANES; lane++) begin
        if (acc.byteEn[lane])
          mem[accAddr][lane*LANE_W +: LANE_W] <= wrData[lane*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vld  <= 1'b0;
      s2Vld  <= 1'b0;
      s3Vld  <= 1'b0;
      s1Addr <= '0;
      s2Data <= '0;
      s3Data <= '0;
    end else begin
      s1Vld  <= acc.rdEn;
      s1Addr <= accAddr;
      s2Vld  <= s1Vld;
      s2Data <= mem[s1Addr];
      s3Vld  <= s2Vld;
      s3Data <= s2Data;
    end
  end

  always_comb begin
    rdValid = s3Vld && !outEnN;
    rdData  = rdValid ? s3Data : '0;
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(acc.rdEn, 3));

  a_r6_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acc.rdEn, acc.wrEn}));
endmodule

// File: rtl/burst_cache_ram.sv
module burst_cache_ram
  import cram_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int REF_PERIOD = 256,
  parameter int REF_LEN    = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  cpuStrbN,
  input  logic                  ctlStrbN,
  input  logic                  burstNextN,
  input  logic                  chipEnN,
  input  logic                  selHi,
  input  logic                  selLoN,
  input  logic                  allWrN,
  input  logic                  laneWrEnN,
  input  logic [BYTE_LANES-1:0] laneSelN,
  input  logic                  outEnN,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  busy
);
  cram_acc_t         acc;
  logic [ADDR_W-1:0] accAddr;
  logic              startReq;
  logic              inBurst;

  cram_ctrl #(.ADDR_W(ADDR_W), .BURST_LEN(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr),
    .cpuStrbN(cpuStrbN), .ctlStrbN(ctlStrbN), .burstNextN(burstNextN),
    .chipEnN(chipEnN), .selHi(selHi), .selLoN(selLoN),
    .allWrN(allWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .busy(busy), .acc(acc), .accAddr(accAddr),
    .startReq(startReq), .inBurst(inBurst)
  );

  cram_refresh #(.REF_PERIOD(REF_PERIOD), .REF_LEN(REF_LEN)) u_refresh (
    .clk(clk), .rstN(rstN), .startReq(startReq), .inBurst(inBurst), .busy(busy)
  );

  cram_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .acc(acc), .accAddr(accAddr),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/burst_cache_ram_bench.sv
module burst_cache_ram_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          cpuStrbN, ctlStrbN, burstNextN, chipEnN, selHi, selLoN;
  logic          allWrN, laneWrEnN, outEnN;
  logic [3:0]    laneSelN;
  logic [31:0]   wrData, rdData;
  logic          rdValid, busy;

  burst_cache_ram #(.ADDR_W(AW)) u_burst_cache_ram (
    .clk(clk), .rstN(rstN), .addr(addr), .cpuStrbN(cpuStrbN), .ctlStrbN(ctlStrbN),
    .burstNextN(burstNextN), .chipEnN(chipEnN), .selHi(selHi), .selLoN(selLoN),
    .allWrN(allWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  always #2.5ns clk = ~clk;

  typedef struct { logic [31:0] data; int due; string tag; } exp_t;
  exp_t        sbq[$];
  logic [31:0] model [1<<AW];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          strayCnt = 0;
  string       quietTag = "R3";
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && rdValid === 1'b1) begin
      if (sbq.size() == 0) begin
        strayCnt++;
        chk(1'b0, quietTag, "unexpected read data", rdData, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rdData === e.data, e.tag, "read data", rdData, e.data);
        chk(cyc == e.due, "R2", "read cycle", cyc, e.due);
      end
    end
  end

  task automatic setIdle();
    cpuStrbN = 1; ctlStrbN = 1; burstNextN = 1;
    chipEnN = 0; selHi = 1; selLoN = 0;
    allWrN = 1; laneWrEnN = 1; laneSelN = 4'hF; wrData = '0;
  endtask

  task automatic idleCyc(input int n);
    setIdle();
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] a, input int i);
    return {a[AW-1:2], 2'(a[1:0] + i)};
  endfunction

  task automatic rdBurst(input logic [AW-1:0] a, input int n, input bit useCtl,
                         input string tag);
    while (busy) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ba;
      ba = beatAddr(a, i);
      setIdle();
      if (i == 0) begin
        addr = a;
        if (useCtl) ctlStrbN = 0; else cpuStrbN = 0;
      end else burstNextN = 0;
      sbq.push_back('{model[ba], cyc + 3, tag});
      @(negedge clk);
    end
    setIdle();
  endtask

  task automatic wrBurst(input logic [AW-1:0] a, input int n, input bit gw, input bit bwe,
                         input logic [3:0] bw, input logic [31:0] base);
    while (busy) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ba;
      logic [31:0]   d;
      ba = beatAddr(a, i);
      d  = base + i * 32'h01010101;
      setIdle();
      if (i == 0) begin addr = a; cpuStrbN = 0; end
      else burstNextN = 0;
      allWrN = gw; laneWrEnN = bwe; laneSelN = bw; wrData = d;
      for (int b = 0; b < 4; b++)
        if (!gw || (!bwe && !bw[b])) model[ba][b*8 +: 8] = d[b*8 +: 8];
      @(negedge clk);
    end
    setIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int busyCnt;
    int strayBefore;
    rstN = 0; outEnN = 0; addr = '0;
    setIdle();
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(rdValid === 1'b0, "R8", "rdValid after reset", 32'(rdValid), 0);
    chk(rdData === 32'h0, "R8", "rdData after reset", rdData, 0);
    chk(busy === 1'b0, "R9", "busy after reset", 32'(busy), 0);

    // R5: global write ignores lane controls
    wrBurst(10'h010, 4, 1'b0, 1'b1, 4'hF, 32'h10203040);
    wrBurst(10'h020, 4, 1'b0, 1'b0, 4'b0101, 32'h55667788);
    // R7: both strobes start a burst
    rdBurst(10'h010, 4, 1'b1, "R7");
    rdBurst(10'h020, 4, 1'b0, "R5");
    idleCyc(3);
    // R3: wrap inside aligned group of four
    rdBurst(10'h012, 4, 1'b0, "R3");
    // R3: advance after the fourth beat is ignored
    burstNextN = 0; @(negedge clk); setIdle();
    rdBurst(10'h021, 1, 1'b1, "R3");
    @(negedge clk);
    burstNextN = 0; @(negedge clk); setIdle();
    idleCyc(4);

    // R6: byte write on lanes 0 and 2 only
    wrBurst(10'h011, 1, 1'b1, 1'b0, 4'b1010, 32'hAABBCCDD);
    idleCyc(1);
    rdBurst(10'h011, 1, 1'b0, "R6");
    idleCyc(1);
    // R6: lane selects without lane write enable give a read
    while (busy) @(negedge clk);
    setIdle(); addr = 10'h013; cpuStrbN = 0; laneSelN = 4'h0; wrData = 32'hFFFFFFFF;
    sbq.push_back('{model[10'h013], cyc + 3, "R6"});
    @(negedge clk); setIdle();
    idleCyc(4);
    rdBurst(10'h013, 1, 1'b0, "R6");
    idleCyc(4);

    // R1: unselected strobes write nothing and read nothing
    quietTag = "R1";
    strayBefore = strayCnt;
    setIdle(); addr = 10'h010; cpuStrbN = 0; allWrN = 0; wrData = 32'h11111111; selHi = 0;
    @(negedge clk);
    chipEnN = 1; selHi = 1; @(negedge clk);
    chipEnN = 0; selLoN = 1; @(negedge clk);
    setIdle(); chipEnN = 1; ctlStrbN = 0; @(negedge clk);
    idleCyc(5);
    chk(strayCnt == strayBefore, "R1", "no read from unselected strobe", strayCnt, strayBefore);
    rdBurst(10'h010, 1, 1'b0, "R1");
    idleCyc(4);
    quietTag = "R3";

    // R8: output gated by outEnN
    while (busy) @(negedge clk);
    outEnN = 1;
    setIdle(); addr = 10'h012; cpuStrbN = 0;
    @(negedge clk); setIdle();
    repeat (2) @(negedge clk);
    chk(rdValid === 1'b0, "R8", "rdValid with output disabled", 32'(rdValid), 0);
    chk(rdData === 32'h0, "R8", "rdData with output disabled", rdData, 0);
    #1 outEnN = 0;
    #1 chk(rdValid === 1'b1 && rdData === model[10'h012], "R8",
           "data after output enabled", rdData, model[10'h012]);
    idleCyc(3);

    // R9: refresh rate in steady idle operation
    idleCyc(300);
    busyCnt = 0;
    repeat (1024) begin
      @(negedge clk);
      if (busy) busyCnt++;
    end
    chk(busyCnt == 4, "R9", "busy cycles per 1024", busyCnt, 4);

    // R11: access during refresh is dropped
    while (!busy) @(negedge clk);
    setIdle(); addr = 10'h010; cpuStrbN = 0; allWrN = 0; wrData = 32'hDEADBEEF;
    @(negedge clk); setIdle();
    idleCyc(2);
    rdBurst(10'h010, 1, 1'b1, "R11");
    idleCyc(4);

    // R4 and R10: back-to-back bursts hold off refresh, which follows at once
    busyCnt = 0;
    for (int k = 0; k < 150; k++) begin
      if (busy) busyCnt++;
      rdBurst(10'h020, 4, k[0], "R4");
    end
    chk(busyCnt == 0, "R10", "busy during burst stream", busyCnt, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R10", "refresh right after stream", 32'(busy), 1);
    idleCyc(6);
    chk(sbq.size() == 0, "R2", "all reads returned", sbq.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule